// File: doc/BRIEF.md
# Ownership label propagation unit

This unit runs beside an execution pipeline and tracks who may see each computed value. Every value carries a label made of a fixed number of owner slots; a slot that is in use names one owner (the slot index is the owner) and holds the set of accessors that owner allows. Combining two labels keeps every owner that appears in either one. When both sides name the same owner, only the accessors both sides allow survive. The accessors that may actually read a value are the accessors allowed by every owner present.

For an ordinary instruction the unit combines the labels of the program counter, the opcode and both source operands into the destination label. For a conditional branch it raises the program-counter label to the combination of the old program-counter label, the opcode label and the tested operand. Combining four wide labels is slow, so results are memoized in a small direct-mapped cache indexed by a hash of the four input labels. A hit completes at once. A miss holds the pipeline for a fixed number of cycles while the result is formed and stored. A save operation pushes the current program-counter label onto a small stack, and a restore operation pops it back, which lowers the label at a committed return point. A separate combinational guard allows a write to an output channel only when every reader of the channel is an allowed accessor of the data being written.

Top module: `label_flow_unit`

## Requirements
- R1: A label is 68 bits: slot i (0..3) occupies bits [17*i+16:17*i], bit 17*i+16 is the slot's in-use flag and bits [17*i+15:17*i] its 16-bit accessor mask. In a combination, a slot is in use if it is in use on either side; its mask is the AND of both masks when both sides use it, the single side's mask when only one does, and zero when neither does.
- R2: An instruction of kind 2'b00 (compute) that is accepted (in_valid high and stall low at a rising edge) drives res_valid high for one cycle after that edge, with res_lbl equal to the combination of pc_lbl, op_lbl, s1_lbl and s2_lbl; no other kind raises res_valid.
- R3: An accepted instruction of kind 2'b01 (branch) sets pc_lbl, from the next cycle on, to the combination of the old pc_lbl, op_lbl and s1_lbl; s2_lbl has no effect. pc_lbl changes only on an accepted branch or restore.
- R4: A combination whose result is still held in the memo cache is accepted in the cycle it is presented, with stall low.
- R5: A compute or branch instruction whose combination is not held in the cache keeps stall high for exactly MISS_LAT+1 cycles (3 by default) while the inputs are held, and is accepted in the next cycle.
- R6: chan_wr equals chan_req when every bit of chan_readers is set in the effective accessor set of chan_data_lbl (the AND of the masks of its in-use slots, all ones when no slot is in use), and is low otherwise; chan_viol is high exactly when chan_req is high and the write is refused, in the same cycle.
- R7: An accepted kind 2'b10 (save) pushes pc_lbl onto a stack of STACK_DEPTH (8) entries; an accepted kind 2'b11 (restore) pops the most recent saved label into pc_lbl, in last-in first-out order.
- R8: A save with the stack full or a restore with the stack empty changes neither the stack nor pc_lbl and sets err, which stays high until reset.
- R9: After reset pc_lbl is all zeros (no owner, unrestricted), the stack and cache are empty, and stall, res_valid and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented |
| in_kind | input | 2 | 00 compute, 01 branch, 10 save, 11 restore |
| op_lbl | input | 68 | Opcode label |
| s1_lbl | input | 68 | First source (or tested) operand label |
| s2_lbl | input | 68 | Second source operand label |
| stall | output | 1 | Instruction not accepted; hold the inputs |
| res_valid | output | 1 | Destination label valid |
| res_lbl | output | 68 | Destination label |
| pc_lbl | output | 68 | Current program-counter label |
| err | output | 1 | Sticky stack overflow/underflow flag |
| chan_req | input | 1 | Channel write requested |
| chan_readers | input | 16 | Potential readers of the channel |
| chan_data_lbl | input | 68 | Label of the data to be written |
| chan_wr | output | 1 | Gated channel write strobe |
| chan_viol | output | 1 | Channel write refused |

## Verification
A cache entry holding the wrong tag or data shows as a destination label that differs from the independently computed combination on the very res_valid pulse that used it, or as a repeated combination that still stalls. A miss counter off by one shows as a stall run of the wrong length on the first use of any combination. A wrong stack pointer shows as the wrong program-counter label one cycle after a restore, or as err rising one save too early or too late, and a wrong accessor reduction shows as chan_wr or chan_viol disagreeing in the same cycle as the request.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
   localparam int N_SLOT = 4;
   localparam int ACC_W  = 16;
   localparam int SLOT_W = ACC_W + 1;
   localparam int LBL_W  = N_SLOT * SLOT_W;
   localparam int KEY_W  = 4 * LBL_W;

   typedef logic [LBL_W-1:0] label_t;

   typedef enum logic [1:0] {
      K_ALU    = 2'b00,
      K_BRANCH = 2'b01,
      K_PUSH   = 2'b10,
      K_POP    = 2'b11
   } kind_e;

   // accessors allowed by every owner present in the label
   function automatic logic [ACC_W-1:0] eff_access(input label_t l);
      logic [ACC_W-1:0] m;
      m = '1;
      for (int i = 0; i < N_SLOT; i++) begin
         if (l[i*SLOT_W + ACC_W]) m = m & l[i*SLOT_W +: ACC_W];
      end
      return m;
   endfunction
endpackage

// File: rtl/lbl_join2.sv
module lbl_join2 import lbl_pkg::*; (
   input  label_t a,
   input  label_t b,
   output label_t o
);
   for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
      logic             av, bv;
      logic [ACC_W-1:0] am, bm, om;
      assign av = a[g*SLOT_W + ACC_W];
      assign bv = b[g*SLOT_W + ACC_W];
      assign am = a[g*SLOT_W +: ACC_W];
      assign bm = b[g*SLOT_W +: ACC_W];
      always_comb begin
         if (av && bv)  om = am & bm;
         else if (av)   om = am;
         else if (bv)   om = bm;
         else           om = '0;
      end
      assign o[g*SLOT_W + ACC_W]  = av | bv;
      assign o[g*SLOT_W +: ACC_W] = om;

      always_comb begin
         AST_JOIN_NARROWS: assert (!av || ((om & ~am) == '0)); // R1
      end
   end
endmodule

// File: rtl/lbl_join_cache.sv
module lbl_join_cache import lbl_pkg::*; #(
   parameter int ENTRIES   = 32,
   parameter bit HASH_FOLD = 1'b1,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [KEY_W-1:0] lk_key,
   output logic             lk_hit,
   output label_t           lk_data,
   input  logic             fill_we,
   input  label_t           fill_data
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0)
      $error("lbl_join_cache: ENTRIES must be a power of two of at least 2");

   logic [IDX_W-1:0] idx;

   if (HASH_FOLD) begin : g_fold
      // every key bit lands in one index bit
      always_comb begin
         idx = '0;
         for (int i = 0; i < KEY_W; i++) idx[i % IDX_W] = idx[i % IDX_W] ^ lk_key[i];
      end
   end else begin : g_low
      // low bits of each label folded together
      always_comb begin
         idx = '0;
         for (int i = 0; i < 4; i++) idx = idx ^ lk_key[i*LBL_W +: IDX_W];
      end
   end

   logic [ENTRIES-1:0] vld_q;
   logic [KEY_W-1:0]   tag_q [ENTRIES];
   label_t             dat_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
      end else if (fill_we) begin
         vld_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) begin
         tag_q[idx] <= lk_key;
         dat_q[idx] <= fill_data;
      end
   end

   assign lk_hit  = vld_q[idx] && (tag_q[idx] == lk_key);
   assign lk_data = dat_q[idx];

   AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
      ($past(fill_we) && $stable(lk_key)) |-> lk_hit); // R4
endmodule

// File: rtl/lbl_pc_stack.sv
module lbl_pc_stack import lbl_pkg::*; #(
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   push,
   input  logic   pop,
   input  label_t din,
   output label_t top,
   output logic   empty,
   output logic   err
);
   if (DEPTH < 1) $error("lbl_pc_stack: DEPTH must be at least 1");

   label_t           mem [DEPTH];
   logic [CNT_W-1:0] cnt_q;
   logic             full;

   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);
   assign top   = empty ? '0 : mem[cnt_q - 1'b1];

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         err   <= 1'b0;
      end else begin
         if (push) begin
            if (full) err <= 1'b1;
            else      cnt_q <= cnt_q + 1'b1;
         end else if (pop) begin
            if (empty) err <= 1'b1;
            else       cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[cnt_q] <= din;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(DEPTH)); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      err |=> err); // R8
   AST_PUSH_ON_TOP: assert property (@(posedge clk) disable iff (rst)
      (push && !full) |=> (top == $past(din))); // R7
endmodule

// File: rtl/lbl_chan_guard.sv
module lbl_chan_guard import lbl_pkg::*; (
   input  logic             req,
   input  logic [ACC_W-1:0] readers,
   input  label_t           data_lbl,
   output logic             wr,
   output logic             viol
);
   logic [ACC_W-1:0] allowed;
   logic             ok;
   logic             any_owner;

   assign allowed = eff_access(data_lbl);
   assign ok      = ((readers & ~allowed) == '0);
   assign wr      = req & ok;
   assign viol    = req & ~ok;

   always_comb begin
      any_owner = 1'b0;
      for (int i = 0; i < N_SLOT; i++) any_owner = any_owner | data_lbl[i*SLOT_W + ACC_W];
   end

   always_comb begin
      AST_PUBLIC_ALWAYS_WRITES: assert (!req || any_owner || wr); // R6
   end
endmodule

// File: rtl/label_flow_unit.sv
module label_flow_unit import lbl_pkg::*; #(
   parameter int CACHE_ENTRIES = 32,
   parameter int MISS_LAT      = 2,
   parameter int STACK_DEPTH   = 8,
   parameter bit HASH_FOLD     = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [1:0]       in_kind,
   input  logic [LBL_W-1:0] op_lbl,
   input  logic [LBL_W-1:0] s1_lbl,
   input  logic [LBL_W-1:0] s2_lbl,
   output logic             stall,
   output logic             res_valid,
   output logic [LBL_W-1:0] res_lbl,
   output logic [LBL_W-1:0] pc_lbl,
   output logic             err,
   input  logic             chan_req,
   input  logic [ACC_W-1:0] chan_readers,
   input  logic [LBL_W-1:0] chan_data_lbl,
   output logic             chan_wr,
   output logic             chan_viol
);
   localparam int LAT_W = $clog2(MISS_LAT + 1);

   if (MISS_LAT < 1) $error("label_flow_unit: MISS_LAT must be at least 1");

   typedef enum logic {S_IDLE, S_FILL} st_e;

   kind_e  kind;
   label_t s2_eff, j_hi, j_lo, j_all, hit_data;
   logic   needs_join, hit, miss, accept, fill_we;
   logic   stk_push, stk_pop, stk_empty;
   label_t stk_top;
   st_e    st_q;
   logic [LAT_W-1:0] cnt_q;

   assign kind       = kind_e'(in_kind);
   assign needs_join = (kind == K_ALU) || (kind == K_BRANCH);
   assign s2_eff     = (kind == K_ALU) ? s2_lbl : '0;

   // combination tree, used only to fill the memo cache
   lbl_join2 u_j_hi  (.a(pc_lbl), .b(op_lbl), .o(j_hi));
   lbl_join2 u_j_lo  (.a(s1_lbl), .b(s2_eff), .o(j_lo));
   lbl_join2 u_j_all (.a(j_hi),   .b(j_lo),   .o(j_all));

   lbl_join_cache #(.ENTRIES(CACHE_ENTRIES), .HASH_FOLD(HASH_FOLD)) u_cache (
      .clk(clk), .rst(rst),
      .lk_key({pc_lbl, op_lbl, s1_lbl, s2_eff}),
      .lk_hit(hit), .lk_data(hit_data),
      .fill_we(fill_we), .fill_data(j_all)
   );

   assign miss    = in_valid && needs_join && !hit;
   assign stall   = (st_q == S_FILL) || miss;
   assign accept  = in_valid && !stall;
   assign fill_we = (st_q == S_FILL) && (cnt_q == LAT_W'(MISS_LAT - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= S_IDLE;
         cnt_q <= '0;
      end else if (st_q == S_IDLE) begin
         if (miss) begin
            st_q  <= S_FILL;
            cnt_q <= '0;
         end
      end else if (fill_we) begin
         st_q <= S_IDLE;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign stk_push = accept && (kind == K_PUSH);
   assign stk_pop  = accept && (kind == K_POP);

   lbl_pc_stack #(.DEPTH(STACK_DEPTH)) u_stack (
      .clk(clk), .rst(rst), .push(stk_push), .pop(stk_pop),
      .din(pc_lbl), .top(stk_top), .empty(stk_empty), .err(err)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_lbl    <= '0;
         res_valid <= 1'b0;
         res_lbl   <= '0;
      end else begin
         res_valid <= accept && (kind == K_ALU);
         if (accept && (kind == K_ALU)) res_lbl <= hit_data;
         if (accept && (kind == K_BRANCH))   pc_lbl <= hit_data;
         else if (stk_pop && !stk_empty)     pc_lbl <= stk_top;
      end
   end

   lbl_chan_guard u_guard (
      .req(chan_req), .readers(chan_readers), .data_lbl(chan_data_lbl),
      .wr(chan_wr), .viol(chan_viol)
   );

   AST_RES_FROM_ALU: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> $past(accept && (kind == K_ALU))); // R2
   AST_PC_STEADY: assert property (@(posedge clk) disable iff (rst)
      !(accept && (kind == K_BRANCH || kind == K_POP)) |=> $stable(pc_lbl)); // R3
   AST_HIT_MATCHES_JOIN: assert property (@(posedge clk) disable iff (rst)
      (in_valid && needs_join && hit) |-> (hit_data == j_all)); // R4
   AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
      (st_q == S_FILL) |-> (cnt_q < LAT_W'(MISS_LAT))); // R5
   AST_FILL_ENDS: assert property (@(posedge clk) disable iff (rst)
      fill_we |=> !miss || !$stable({pc_lbl, op_lbl, s1_lbl, s2_eff})); // R5
endmodule

// File: tb/label_flow_unit_test.sv
`timescale 1ns/1ps
module label_flow_unit_test;
   import lbl_pkg::*;

   logic clk = 1'b0, rst = 1'b1;
   logic in_valid = 1'b0;
   logic [1:0] in_kind = 2'b00;
   label_t op_lbl = '0, s1_lbl = '0, s2_lbl = '0;
   logic stall, res_valid, err, chan_wr, chan_viol;
   label_t res_lbl, pc_lbl, chan_data_lbl = '0;
   logic chan_req = 1'b0;
   logic [ACC_W-1:0] chan_readers = '0;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   label_t exp_q[$];
   label_t pc_exp;
   label_t stk_m[$];

   always #2.5 clk = ~clk;

   label_flow_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
      .op_lbl(op_lbl), .s1_lbl(s1_lbl), .s2_lbl(s2_lbl),
      .stall(stall), .res_valid(res_valid), .res_lbl(res_lbl),
      .pc_lbl(pc_lbl), .err(err),
      .chan_req(chan_req), .chan_readers(chan_readers),
      .chan_data_lbl(chan_data_lbl), .chan_wr(chan_wr), .chan_viol(chan_viol)
   );

   function automatic label_t mk(input logic [3:0] use_s, input logic [15:0] m3, m2, m1, m0);
      logic [15:0] ms [4];
      label_t l;
      ms[0] = m0; ms[1] = m1; ms[2] = m2; ms[3] = m3;
      l = '0;
      for (int s = 0; s < 4; s++)
         if (use_s[s]) l[17*s +: 17] = {1'b1, ms[s]};
      return l;
   endfunction

   // reference combination written from R1
   function automatic label_t rj(input label_t x, input label_t y);
      label_t r;
      r = '0;
      for (int s = 0; s < 4; s++) begin
         case ({x[17*s+16], y[17*s+16]})
            2'b11: r[17*s +: 17] = {1'b1, x[17*s +: 16] & y[17*s +: 16]};
            2'b10: r[17*s +: 17] = {1'b1, x[17*s +: 16]};
            2'b01: r[17*s +: 17] = {1'b1, y[17*s +: 16]};
            default: r[17*s +: 17] = '0;
         endcase
      end
      return r;
   endfunction

   function automatic logic [15:0] ref_allowed(input label_t l);
      logic [15:0] m;
      m = 16'hFFFF;
      for (int s = 0; s < 4; s++) if (l[17*s+16]) m = m & l[17*s +: 16];
      return m;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && res_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected res_valid", 1, 0);
         end else begin
            label_t e;
            e = exp_q.pop_front();
            chk(res_lbl == e, "R1/R2", "destination label", res_lbl, e);
         end
      end
   end

   // driver: presents one instruction, waits for acceptance, pushes expectations
   task automatic issue(input kind_e k, input label_t o, input label_t a,
                        input label_t b, output int waits);
      @(negedge clk);
      in_valid = 1'b1; in_kind = k; op_lbl = o; s1_lbl = a; s2_lbl = b;
      waits = 0;
      forever begin
         #0.5;
         if (!stall) break;
         waits++;
         @(negedge clk);
      end
      case (k)
         K_ALU:    exp_q.push_back(rj(rj(pc_exp, o), rj(a, b)));
         K_BRANCH: pc_exp = rj(rj(pc_exp, o), a);
         K_PUSH:   if (stk_m.size() < 8) stk_m.push_back(pc_exp);
         K_POP:    if (stk_m.size() > 0) pc_exp = stk_m.pop_back();
         default: ;
      endcase
      @(negedge clk);
      in_valid = 1'b0;
      #0.5;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      pc_exp = '0;
      stk_m.delete();
      #0.5;
   endtask

   task automatic chan(input logic rq, input logic [15:0] rd, input label_t dl,
                       input logic ew, input logic ev, input string what);
      @(negedge clk);
      chan_req = rq; chan_readers = rd; chan_data_lbl = dl;
      #0.5;
      chk(chan_wr == ew, "R6", {what, " wr"}, chan_wr, ew);
      chk(chan_viol == ev, "R6", {what, " viol"}, chan_viol, ev);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int w;
      label_t la, lb, lc, p1, p2;
      pc_exp = '0;
      do_reset();

      // R9 reset state
      chk(pc_lbl == '0, "R9", "pc after reset", pc_lbl, 0);
      chk(!stall && !res_valid && !err, "R9", "flags after reset",
          {stall, res_valid, err}, 0);

      // R5 cold miss, R1 same-owner masks ANDed
      la = mk(4'b0001, 0, 0, 0, 16'h00FF);
      lb = mk(4'b0001, 0, 0, 0, 16'h0F0F);
      lc = mk(4'b0011, 0, 0, 16'hAAAA, 16'h0033);
      issue(K_ALU, la, lb, lc, w);
      chk(w == 3, "R5", "miss stall cycles", w, 3);

      // R4 repeated combination hits
      issue(K_ALU, la, lb, lc, w);
      chk(w == 0, "R4", "repeat stall cycles", w, 0);

      // R1 disjoint owners union
      issue(K_ALU, mk(4'b0100, 0, 16'h1234, 0, 0), mk(4'b1000, 16'h8001, 0, 0, 0), '0, w);
      chk(w == 3, "R5", "second miss stall cycles", w, 3);

      // R3 branch raises pc; s2 has no effect
      issue(K_BRANCH, mk(4'b0010, 0, 0, 16'hFF00, 0), mk(4'b0011, 0, 0, 16'h0FF0, 16'h00F0),
            mk(4'b1111, 16'h1, 16'h1, 16'h1, 16'h1), w);
      chk(pc_lbl == pc_exp, "R3", "pc after branch", pc_lbl, pc_exp);
      p1 = pc_exp;

      // R2 compute after branch carries pc label
      issue(K_ALU, mk(4'b1000, 16'h00F0, 0, 0, 0), lb, mk(4'b0010, 0, 0, 16'h0F00, 0), w);

      // R7 save, raise, save, raise, restore twice
      issue(K_PUSH, '0, '0, '0, w);
      chk(w == 0, "R7", "save never stalls", w, 0);
      issue(K_BRANCH, mk(4'b0100, 0, 16'h00FF, 0, 0), '0, '0, w);
      p2 = pc_exp;
      issue(K_PUSH, '0, '0, '0, w);
      issue(K_BRANCH, mk(4'b0001, 0, 0, 0, 16'h0003), '0, '0, w);
      chk(pc_lbl == pc_exp, "R3", "pc after second branch", pc_lbl, pc_exp);
      issue(K_POP, '0, '0, '0, w);
      chk(pc_lbl == p2, "R7", "first restore", pc_lbl, p2);
      issue(K_POP, '0, '0, '0, w);
      chk(pc_lbl == p1, "R7", "second restore", pc_lbl, p1);
      chk(!err, "R8", "no error on balanced use", err, 0);

      // R8 restore on empty
      issue(K_POP, '0, '0, '0, w);
      chk(err, "R8", "underflow sets err", err, 1);
      chk(pc_lbl == p1, "R8", "pc kept on underflow", pc_lbl, p1);
      issue(K_ALU, la, lb, lc, w);
      chk(err, "R8", "err sticky", err, 1);

      // R9 reset again, then overflow
      do_reset();
      chk(!err && pc_lbl == '0, "R9", "state after second reset", {err, pc_lbl}, 0);
      issue(K_BRANCH, mk(4'b0010, 0, 0, 16'h7777, 0), '0, '0, w);
      p1 = pc_exp;
      for (int i = 0; i < 8; i++) issue(K_PUSH, '0, '0, '0, w);
      chk(!err, "R8", "eight saves fit", err, 0);
      issue(K_BRANCH, mk(4'b0010, 0, 0, 16'h0007, 0), '0, '0, w);
      issue(K_PUSH, '0, '0, '0, w);
      chk(err, "R8", "ninth save sets err", err, 1);
      issue(K_POP, '0, '0, '0, w);
      chk(pc_lbl == p1, "R8", "overflowing save not stored", pc_lbl, p1);

      // R6 channel guard
      chan(1'b1, 16'h0003, mk(4'b0011, 0, 0, 16'h00FF, 16'h000F), 1'b1, 1'b0, "subset");
      chan(1'b1, 16'h0013, mk(4'b0011, 0, 0, 16'h00FF, 16'h000F), 1'b0, 1'b1, "not subset");
      chan(1'b1, 16'hFFFF, '0, 1'b1, 1'b0, "no owner");
      chan(1'b0, 16'h0013, mk(4'b0001, 0, 0, 0, 16'h0001), 1'b0, 1'b0, "no request");
      begin
         label_t dl;
         logic [15:0] rd;
         dl = mk(4'b1001, 16'hF0F0, 0, 0, 16'hFF00);
         rd = 16'h5000;
         chan(1'b1, rd, dl, (rd & ~ref_allowed(dl)) == 0, (rd & ~ref_allowed(dl)) != 0, "two owners");
      end
      chan(1'b0, '0, '0, 1'b0, 1'b0, "idle");

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R2", "all results delivered", exp_q.size(), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule